// File: doc/BRIEF.md
# Chirp Direct Digital Synthesizer

This block synthesizes a linear frequency sweep as a stream of signed sine samples. It runs two accumulators in series. The first holds the phase increment. It is loaded with a start frequency word and then grows by a signed slope word for every sample produced. The second adds that increment into a free-running phase that wraps modulo 2^ACC_W, which gives one wrap per output cycle. The top phase bits address a quarter-wave magnitude table. The table is computed during elaboration, and the quadrant bits rebuild the full period by mirroring and negation. The lookup is registered, and the valid flag is produced in step with it.

A pulse on `start` captures the start frequency, the slope and the chirp length, and discards any samples still in flight. The block then emits exactly the programmed number of samples. After the last one it raises `done` and freezes its accumulators, so the final frequency is held. The output is a valid/ready stream. While `out_valid` is high and `out_ready` is low, the sample is held unchanged and both accumulators stall, so no sample is dropped or skipped.

Top module: `chirp_dds`

## Requirements
- R1: After reset, `out_valid` and `done` are both 0.
- R2: The cycle after `start` is sampled high, `out_valid` is 0, and `done` is 0 unless the captured length is zero. The first sample appears one cycle later and uses phase 0.
- R3: Between two consecutive emitted samples, the phase advances by the current increment, modulo 2^ACC_W.
- R4: Between two consecutive emitted samples, the increment advances by the two's-complement slope, modulo 2^ACC_W. The first sample uses the start frequency word.
- R5: Let j be the top LUT_ADDR_W phase bits. Its top two bits q2 select the quadrant, and its remaining bits form k. Write Q = 2^(LUT_ADDR_W-2), A = 2^(AMP_W-1)-1 and m(x) = floor(A*sin(pi*(2x+1)/(4Q)) + 0.5). The sample is then m(k) when q2=0, m(Q-1-k) when q2=1, -m(k) when q2=2 and -m(Q-1-k) when q2=3.
- R6: While `out_valid`=1 and `out_ready`=0, the next cycle keeps `out_valid`=1 and the same `out_sample`, and no sample is lost.
- R7: A chirp of length L delivers exactly L samples. `done` rises in the cycle the last sample is presented and stays high until the next `start`. When L=0, `done` rises one cycle after `start` and no sample is produced.
- R8: A `start` during a chirp discards the remaining samples and restarts from the newly captured parameters.
- R9: Once `done` is high and the last sample has been accepted, `out_valid` stays 0 until the next `start`.
- R10: Every emitted sample lies within [-A, A].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse; captures the parameters and restarts the chirp |
| freq_start | input | ACC_W | Initial phase increment |
| freq_slope | input | ACC_W | Signed increment added per emitted sample |
| chirp_len | input | LEN_W | Number of samples in the chirp |
| out_sample | output | AMP_W | Signed sine sample |
| out_valid | output | 1 | Sample available |
| out_ready | input | 1 | Consumer accepts the sample |
| done | output | 1 | Chirp finished; held until next start |

## Verification
The hardest situation to reach from the ports is a stall that lands exactly on the last sample of a chirp, or a restart issued while a sample is being held. In both cases the done flag, the held sample and the frozen accumulators have to agree. The stimulus drives `out_ready` from a pseudo-random sequence over long chirps, so stalls fall on many sample positions, including the final one. It also aborts one chirp part-way through while back-pressure is active. A further sweep uses a large increment and a slope that make the increment itself wrap. A separate flat chirp visits every table address exactly once.

// File: rtl/chirp_dds_pkg.sv
package chirp_dds_pkg;
  localparam real CIRCLE_HALF = 3.141592653589793;

  typedef enum logic [1:0] {
    QD_RISE  = 2'd0,
    QD_FALL  = 2'd1,
    QD_NRISE = 2'd2,
    QD_NFALL = 2'd3
  } quadrant_e;
endpackage

// File: rtl/chirp_freq_acc.sv
module chirp_freq_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ACC_W-1:0] load_val,
  input  logic [ACC_W-1:0] slope_val,
  input  logic             step,
  output logic [ACC_W-1:0] inc_o
);
  logic [ACC_W-1:0] slope_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_o   <= '0;
      slope_q <= '0;
    end else if (load) begin
      inc_o   <= load_val;
      slope_q <= slope_val;
    end else if (step) begin
      inc_o <= inc_o + slope_q;
    end
  end
endmodule

// File: rtl/chirp_phase_acc.sv
module chirp_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [ACC_W-1:0] inc_i,
  output logic [ACC_W-1:0] phase_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     phase_o <= '0;
    else if (clear) phase_o <= '0;
    else if (step)  phase_o <= phase_o + inc_i;
  end
endmodule

// File: rtl/chirp_sine_lut.sv
module chirp_sine_lut
  import chirp_dds_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int AMP_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [ADDR_W-1:0]       addr,
  output logic signed [AMP_W-1:0] sample_o
);
  localparam int Q_W   = ADDR_W - 2;
  localparam int QN    = 1 << Q_W;
  localparam int PEAK  = (1 << (AMP_W - 1)) - 1;

  logic [AMP_W-2:0] rom [QN];

  for (genvar k = 0; k < QN; k++) begin : g_rom
    localparam real ANG = CIRCLE_HALF * real'(2 * k + 1) / real'(4 * QN);
    localparam int  MAG = $rtoi(real'(PEAK) * $sin(ANG) + 0.5);
    assign rom[k] = MAG[AMP_W-2:0];
  end

  quadrant_e        quad;
  logic [Q_W-1:0]   idx;
  logic [AMP_W-2:0] mag;
  logic signed [AMP_W-1:0] value;

  always_comb begin
    quad = quadrant_e'(addr[ADDR_W-1 -: 2]);
    unique case (quad)
      QD_FALL, QD_NFALL: idx = ~addr[Q_W-1:0];
      default:           idx = addr[Q_W-1:0];
    endcase
    mag = rom[idx];
    unique case (quad)
      QD_NRISE, QD_NFALL: value = -$signed({1'b0, mag});
      default:            value = $signed({1'b0, mag});
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sample_o <= '0;
    else if (en) sample_o <= value;
  end
endmodule

// File: rtl/chirp_seq.sv
module chirp_seq #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len_i,
  input  logic             advance,
  output logic             emit,
  output logic             step,
  output logic             done
);
  logic             running;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] len_q;
  logic             last;

  assign emit = advance && running && !start;
  assign last = (LEN_W'(cnt + 1'b1) == len_q);
  assign step = emit && !last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      len_q   <= '0;
      done    <= 1'b0;
    end else if (start) begin
      running <= (len_i != '0);
      cnt     <= '0;
      len_q   <= len_i;
      done    <= (len_i == '0);
    end else if (emit) begin
      cnt <= cnt + 1'b1;
      if (last) begin
        running <= 1'b0;
        done    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/chirp_dds.sv
module chirp_dds #(
  parameter int ACC_W      = 32,
  parameter int LUT_ADDR_W = 8,
  parameter int AMP_W      = 12,
  parameter int LEN_W      = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [ACC_W-1:0]        freq_start,
  input  logic [ACC_W-1:0]        freq_slope,
  input  logic [LEN_W-1:0]        chirp_len,
  output logic signed [AMP_W-1:0] out_sample,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    done
);
  localparam int TOP = ACC_W - 1;

  logic             advance;
  logic             emit;
  logic             step;
  logic [ACC_W-1:0] inc;
  logic [ACC_W-1:0] phase;

  assign advance = !out_valid || out_ready;

  chirp_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .len_i(chirp_len),
    .advance(advance), .emit(emit), .step(step), .done(done)
  );

  chirp_freq_acc #(.ACC_W(ACC_W)) u_freq (
    .clk(clk), .rst_n(rst_n), .load(start), .load_val(freq_start),
    .slope_val(freq_slope), .step(step), .inc_o(inc)
  );

  chirp_phase_acc #(.ACC_W(ACC_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .clear(start), .step(step),
    .inc_i(inc), .phase_o(phase)
  );

  chirp_sine_lut #(.ADDR_W(LUT_ADDR_W), .AMP_W(AMP_W)) u_lut (
    .clk(clk), .rst_n(rst_n), .en(emit),
    .addr(phase[TOP -: LUT_ADDR_W]), .sample_o(out_sample)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out_valid <= 1'b0;
    else if (start)   out_valid <= 1'b0;
    else if (advance) out_valid <= emit;
  end
endmodule

// File: rtl/chirp_dds_checker.sv
module chirp_dds_checker #(
  parameter int AMP_W = 12,
  parameter int LEN_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic [LEN_W-1:0]        chirp_len,
  input logic signed [AMP_W-1:0] out_sample,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic                    done
);
  localparam int PEAK = (1 << (AMP_W - 1)) - 1;

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> !out_valid && !done);

  a_r2_start_flush: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !out_valid);

  a_r2_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
    (start && chirp_len != '0) |=> !done);

  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start) |=> out_valid && $stable(out_sample));

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  a_r9_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !out_valid && !start) |=> !out_valid);

  a_r10_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sample <= PEAK) && (out_sample >= -PEAK));
endmodule

bind chirp_dds chirp_dds_checker #(.AMP_W(AMP_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .chirp_len(chirp_len),
  .out_sample(out_sample), .out_valid(out_valid), .out_ready(out_ready),
  .done(done)
);

// File: tb/sim_chirp_dds.sv
module sim_chirp_dds;
  localparam int ACC_W = 32;
  localparam int LA    = 8;
  localparam int AMP_W = 12;
  localparam int LEN_W = 16;
  localparam int QN    = 1 << (LA - 2);
  localparam int PEAK  = (1 << (AMP_W - 1)) - 1;
  localparam real PI_R = 3.141592653589793;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ACC_W-1:0] freq_start = '0;
  logic [ACC_W-1:0] freq_slope = '0;
  logic [LEN_W-1:0] chirp_len = '0;
  logic signed [AMP_W-1:0] out_sample;
  logic out_valid;
  logic out_ready = 1'b0;
  logic done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  chirp_dds #(.ACC_W(ACC_W), .LUT_ADDR_W(LA), .AMP_W(AMP_W), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .freq_start(freq_start),
    .freq_slope(freq_slope), .chirp_len(chirp_len), .out_sample(out_sample),
    .out_valid(out_valid), .out_ready(out_ready), .done(done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL R7 watchdog expired: actual cycles=%0d expected < 150000", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  function automatic int mag(int k);
    real ang;
    ang = PI_R * real'(2 * k + 1) / real'(4 * QN);
    return $rtoi(real'(PEAK) * $sin(ang) + 0.5);
  endfunction

  function automatic int model_sample(logic [ACC_W-1:0] ph);
    int j, q2, k;
    j  = int'(ph[ACC_W-1 -: LA]);
    q2 = j / QN;
    k  = j % QN;
    case (q2)
      0: return mag(k);
      1: return mag(QN - 1 - k);
      2: return -mag(k);
      default: return -mag(QN - 1 - k);
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_ready(bit random);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = random ? (lfsr[0] | lfsr[3]) : 1'b1;
  endtask

  // Runs a chirp; stop_after < len aborts after that many accepted samples.
  task automatic run_chirp(logic [ACC_W-1:0] f0, logic [ACC_W-1:0] sl,
                           int len, bit random, int stop_after);
    logic [ACC_W-1:0] ph, inc;
    int got;
    bit stalled;
    int held;
    freq_start = f0;
    freq_slope = sl;
    chirp_len  = LEN_W'(len);
    start      = 1'b1;
    out_ready  = 1'b0;
    @(negedge clk);
    start = 1'b0;
    // R2: flushed, done cleared unless zero length
    check(!out_valid, "R2 valid after start", int'(out_valid), 0);
    check(done == (len == 0), "R2 done after start", int'(done), int'(len == 0));
    ph = '0;
    inc = f0;
    got = 0;
    stalled = 1'b0;
    held = 0;
    while (got < len && got < stop_after) begin
      next_ready(random);
      if (stalled)
        check(out_valid && int'(out_sample) == held, "R6 stall hold",
              int'(out_sample), held);
      stalled = 1'b0;
      if (out_valid) begin
        if (got < len - 1)
          check(!done, "R7 done early", int'(done), 0);
        else
          check(done, "R7 done on last", int'(done), 1);
        if (out_ready) begin
          // R3 R4 R5: sample from model phase/increment recurrences
          check(int'(out_sample) == model_sample(ph), "R5 sample value",
                int'(out_sample), model_sample(ph));
          ph  = ph + inc;
          inc = inc + sl;
          got = got + 1;
        end else begin
          stalled = 1'b1;
          held = int'(out_sample);
        end
      end
      @(negedge clk);
    end
    if (stop_after >= len) begin
      out_ready = 1'b1;
      repeat (3) @(negedge clk);
      check(!out_valid, "R9 quiet after done", int'(out_valid), 0);
      check(done, "R7 done held", int'(done), 1);
      check(got == len, "R7 sample count", got, len);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && !done, "R1 reset state", int'({out_valid, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !done, "R1 idle after reset", int'({out_valid, done}), 0);

    // R5: flat chirp visiting every table address once
    run_chirp(32'h0100_0000, 32'h0, 256, 1'b0, 1 << 20);
    // R4: rising sweep under random back-pressure (R6)
    run_chirp(32'h0010_0000, 32'h0000_1000, 600, 1'b1, 1 << 20);
    // R4: falling sweep with negative slope
    run_chirp(32'h4000_0000, -32'sh0001_0000, 300, 1'b1, 1 << 20);
    // R3 R4: large increment and slope so increment wraps
    run_chirp(32'hF000_0000, 32'h0100_0000, 100, 1'b1, 1 << 20);
    // R7: boundary lengths
    run_chirp(32'h1234_5678, 32'h0000_0100, 1, 1'b1, 1 << 20);
    run_chirp(32'h1234_5678, 32'h0000_0100, 0, 1'b0, 1 << 20);
    // R8: abort a chirp mid-way under stalls, then restart
    run_chirp(32'h0200_0000, 32'h0000_2000, 500, 1'b1, 37);
    run_chirp(32'h0333_0000, 32'hFFFF_F000, 200, 1'b1, 1 << 20);
    // R8: abort while the output is held, then restart without back-pressure
    run_chirp(32'h0080_0000, 32'h0, 400, 1'b1, 10);
    out_ready = 1'b0;
    repeat (2) @(negedge clk);
    run_chirp(32'h0300_0000, 32'h0000_0400, 150, 1'b0, 1 << 20);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule